// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects an on-chip request port to an external static RAM that has no clock. The RAM has a single bidirectional byte-wide data bus, a 15-bit word address and three active-low strobes: select, write strobe and read gate. A requester offers one access at a time with a valid/ready handshake. Each access carries an address, a direction flag and, for a store, a byte. A load returns its byte with a one-cycle response pulse.

Every RAM timing limit is turned into a whole number of clock cycles. The conversion rounds up and starts from the clock period and the speed grade of the part (10, 12, 15 or 20 ns), both of which are parameters. Each phase is at least one cycle long. Stores are finished by the rising edge of the write strobe while select is still low. Address and store data are held from one cycle before that strobe falls until one cycle after it rises. After a load there is a turnaround gap before the bus is driven again. Between accesses the RAM is left deselected, in standby.

Top module: `asram_ctrl`

## Requirements
- R1: The cycle after reset is released, all three strobes are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: While no access is in progress (`req_ready` high), `mem_ce_n` is high and `mem_dq_oe` is low.
- R3: A store takes one setup cycle with select low, write strobe high and address and data driven. The write strobe is then low for the pulse length, with select low. Finally there is one hold cycle with the strobe high and select low and data still driven. After that, select goes high.
- R4: A store writes the accepted byte at the accepted address, and a later load of that address returns it. A newer store to the same address replaces the older byte.
- R5: A load holds select and the read gate low and the write strobe high for the read length. The controller does not drive the bus during that time.
- R6: The byte on `mem_dq_i` at the end of the last read cycle is put on `rsp_rdata` in the next cycle. `rsp_valid` is high for exactly that one cycle, once per load.
- R7: After a load, select and the read gate stay high and the bus stays undriven for the turnaround length before the next access can start.
- R8: `req_ready` drops in the cycle after a request is accepted. It stays low until the access and any turnaround have finished.
- R9: `mem_dq_oe` is never high while `mem_oe_n` is low, and never high in the cycle right after the read gate rises.
- R10: Phase lengths are ceiling(time / `CLK_PERIOD_NS`), with a minimum of 1. With the 20 ns grade and a 10 ns clock, the write pulse is 2 cycles, the read is 2 cycles and the turnaround is 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, takes a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store byte |
| rsp_valid | output | 1 | One-cycle load response pulse |
| rsp_rdata | output | DATA_W | Load result |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM read gate, active low |
| mem_addr | output | ADDR_W | RAM address |
| mem_dq_o | output | DATA_W | Bus value driven by the controller |
| mem_dq_oe | output | 1 | Controller drives the bus |
| mem_dq_i | input | DATA_W | Bus value seen by the controller |

## Verification
The assertions check on every cycle the rules that hold at any moment. These are: standby while idle, select low whenever the write strobe is low, address and data held around the strobe edges, no bus drive while the read gate is open or in the cycle after it closes, the single-cycle response pulse, and ready dropping after acceptance. Only the bench scenarios can show the exact phase lengths for a chosen grade and clock. They also show whether stored bytes come back from a model RAM, that an overwrite replaces the older byte, and that the top address reaches the pins. Finally, they show that the model RAM never drives the bus at the same time as the controller.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_RTURN
    } asram_state_t;

    typedef enum logic [2:0] {
        TM_ACCESS,
        TM_GATE,
        TM_PULSE,
        TM_SELECT,
        TM_ADDRV,
        TM_DATAV,
        TM_FLOAT
    } asram_tm_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // ceiling division with a floor of one cycle
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // timing minimum (ns) for a grade; unknown grades use the slowest set
    function automatic int unsigned grade_ns(input int unsigned grade, input asram_tm_t tm);
        int unsigned v;
        case (grade)
            10: case (tm)
                    TM_ACCESS: v = 10; TM_GATE: v = 5; TM_PULSE: v = 7;
                    TM_SELECT: v = 8;  TM_ADDRV: v = 8; TM_DATAV: v = 5;
                    default:   v = 5;
                endcase
            12: case (tm)
                    TM_ACCESS: v = 12; TM_GATE: v = 6; TM_PULSE: v = 8;
                    TM_SELECT: v = 8;  TM_ADDRV: v = 8; TM_DATAV: v = 6;
                    default:   v = 6;
                endcase
            15: case (tm)
                    TM_ACCESS: v = 15; TM_GATE: v = 7; TM_PULSE: v = 9;
                    TM_SELECT: v = 10; TM_ADDRV: v = 10; TM_DATAV: v = 8;
                    default:   v = 7;
                endcase
            default: case (tm)
                    TM_ACCESS: v = 20; TM_GATE: v = 8; TM_PULSE: v = 12;
                    TM_SELECT: v = 12; TM_ADDRV: v = 12; TM_DATAV: v = 10;
                    default:   v = 8;
                endcase
        endcase
        return v;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    assign done = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (!done) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int RD_CYC  = 1,
    parameter int WP_CYC  = 1,
    parameter int HZ_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic             t_done,
    output asram_state_t     state,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             accept,
    output logic             sample
);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);

    asram_state_t nxt;

    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        accept = 1'b0;
        sample = 1'b0;
        case (state)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                t_load = 1'b1;
                if (req_we) begin
                    nxt = ST_WSETUP;
                end else begin
                    nxt   = ST_RACC;
                    t_val = RD_LD;
                end
            end
            ST_WSETUP: if (t_done) begin
                nxt    = ST_WPULSE;
                t_load = 1'b1;
                t_val  = WP_LD;
            end
            ST_WPULSE: if (t_done) begin
                nxt    = ST_WHOLD;
                t_load = 1'b1;
            end
            ST_WHOLD: if (t_done) nxt = ST_IDLE;
            ST_RACC: if (t_done) begin
                sample = 1'b1;
                nxt    = ST_RTURN;
                t_load = 1'b1;
                t_val  = HZ_LD;
            end
            ST_RTURN: if (t_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              sample,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (sample) rdata_q <= mem_dq_i;
            rvalid_q <= sample;
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int GRADE_NS      = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned CK = CLK_PERIOD_NS;
    localparam int unsigned GR = GRADE_NS;
    localparam int RD_CYC = int'(max2(ns2cyc(grade_ns(GR, TM_ACCESS), CK),
                                      ns2cyc(grade_ns(GR, TM_GATE), CK)));
    // setup cycle already gives select and address one extra cycle
    localparam int WP_CYC = int'(max2(max2(ns2cyc(grade_ns(GR, TM_PULSE), CK),
                                           ns2cyc(grade_ns(GR, TM_DATAV), CK)),
                                      max2(ns2cyc(grade_ns(GR, TM_SELECT), CK) - 1,
                                           ns2cyc(grade_ns(GR, TM_ADDRV), CK) - 1)));
    localparam int HZ_CYC = int'(ns2cyc(grade_ns(GR, TM_FLOAT), CK));
    localparam int MAX_CYC = int'(max2(max2(RD_CYC, WP_CYC), HZ_CYC));
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    asram_state_t     state;
    logic             t_load, t_done, accept, sample;
    logic [CNT_W-1:0] t_val;

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
    );

    asram_fsm #(.CNT_W(CNT_W), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .HZ_CYC(HZ_CYC)) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .t_done(t_done), .state(state), .t_load(t_load), .t_val(t_val),
        .accept(accept), .sample(sample)
    );

    asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk(clk), .rst(rst), .accept(accept), .sample(sample),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_i(mem_dq_i),
        .addr_q(mem_addr), .wdata_q(mem_dq_o), .rdata_q(rsp_rdata), .rvalid_q(rsp_valid)
    );

    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_ce_n  = !(state inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACC});
        mem_we_n  = (state != ST_WPULSE);
        mem_oe_n  = (state != ST_RACC);
        mem_dq_oe = (state inside {ST_WSETUP, ST_WPULSE, ST_WHOLD});
    end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    p_standby_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && !mem_dq_oe));

    p_strobe_sel_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_dq_oe));

    p_setup_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> ($past(mem_dq_oe) && !$past(mem_ce_n)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr) && $stable(mem_dq_o)));

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_o)));

    p_read_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    p_no_contend_r9: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (!mem_dq_oe && mem_ce_n));

    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;
    localparam int AW = 15;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [AW-1:0] mem_addr;

    int checks = 0, fails = 0, rsp_seen = 0, loads = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    asram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(10), .GRADE_NS(20)) i_asram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // behavioural RAM: 256 bytes, indexed by the low address byte
    logic [DW-1:0] ram [256];
    logic ram_drive;
    assign ram_drive = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq_i  = ram_drive ? ram[mem_addr[7:0]] : 8'h00;

    always @(posedge mem_we_n) if (!mem_ce_n && mem_dq_oe) ram[mem_addr[7:0]] <= mem_dq_o;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // model-side monitor: contention, write pulse width, response count
    int low_run = 0;
    always @(negedge clk) if (!rst && !done_flag) begin
        if (ram_drive && mem_dq_oe) chk(1'b0, "R9 bus contention", 1, 0);
        if (rsp_valid) rsp_seen++;
        if (!mem_we_n) low_run++;
        else if (low_run != 0) begin
            chk(low_run == 2, "R10 write pulse cycles", low_run, 2);
            low_run = 0;
        end
    end

    task automatic run_vec(input bit we, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic [DW-1:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a; req_wdata = ~d;
        chk(!req_ready, "R8 ready low after accept", req_ready, 0);
        if (we) begin
            chk(!mem_ce_n && mem_we_n && mem_dq_oe, "R3 setup cycle", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b011);
            chk(mem_addr == a && mem_dq_o == d, "R3 setup addr/data", {mem_addr, mem_dq_o}, {a, d});
            for (int i = 0; i < 2; i++) begin
                @(negedge clk);
                chk(!mem_we_n && !mem_ce_n && mem_dq_oe, "R3 pulse cycle", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b001);
            end
            @(negedge clk);
            chk(mem_we_n && !mem_ce_n && mem_dq_oe && mem_dq_o == d, "R3 hold cycle",
                {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b011);
            @(negedge clk);
            chk(mem_ce_n && !mem_dq_oe && req_ready, "R2 standby after store",
                {mem_ce_n, mem_dq_oe, req_ready}, 3'b101);
        end else begin
            loads++;
            for (int i = 0; i < 2; i++) begin
                chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R5 read cycle",
                    {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
                chk(!rsp_valid, "R6 no early response", rsp_valid, 0);
                @(negedge clk);
            end
            chk(rsp_valid && rsp_rdata == exp, "R4/R6 load data", rsp_rdata, exp);
            chk(mem_ce_n && mem_oe_n && !mem_dq_oe && !req_ready, "R7 turnaround",
                {mem_ce_n, mem_oe_n, mem_dq_oe, req_ready}, 4'b1100);
            @(negedge clk);
            chk(req_ready && !rsp_valid, "R8 ready after turnaround", {req_ready, rsp_valid}, 2'b10);
        end
    endtask

    // {we, addr[14:0], wdata, expected}
    localparam int NV = 8;
    localparam logic [31:0] VECS [NV] = '{
        {1'b1, 15'h0012, 8'hA5, 8'h00},
        {1'b1, 15'h7FFF, 8'h3C, 8'h00},
        {1'b1, 15'h0003, 8'h5A, 8'h00},
        {1'b0, 15'h0012, 8'h00, 8'hA5},
        {1'b0, 15'h7FFF, 8'h00, 8'h3C},
        {1'b1, 15'h0012, 8'hC3, 8'h00},
        {1'b0, 15'h0012, 8'h00, 8'hC3},
        {1'b0, 15'h0003, 8'h00, 8'h5A}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes after reset",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        chk(req_ready && !rsp_valid, "R1 ready after reset", {req_ready, rsp_valid}, 2'b10);

        for (int v = 0; v < NV; v++)
            run_vec(VECS[v][31], VECS[v][30:16], VECS[v][15:8], VECS[v][7:0]);

        // corner: store right after a load (turnaround then drive), read-back
        run_vec(1'b0, 15'h0003, 8'h00, 8'h5A);
        run_vec(1'b1, 15'h0044, 8'hFF, 8'h00);
        run_vec(1'b0, 15'h0044, 8'h00, 8'hFF);
        // corner: idle with no request keeps standby
        repeat (3) begin
            @(negedge clk);
            chk(mem_ce_n && !mem_dq_oe && req_ready, "R2 idle standby",
                {mem_ce_n, mem_dq_oe, req_ready}, 3'b101);
        end
        chk(rsp_seen == loads, "R6 one response per load", rsp_seen, loads);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        done_flag = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule